// File: doc/BRIEF.md
# ATA Taskfile Load Sequencer

This block sits on the host side of a parallel ATA register bus. It accepts one request at a time and turns it into an ordered series of single register accesses. There are two operations. A load selects the device, waits for BUSY to clear, enables interrupts, writes the taskfile and writes the command register last. A readback recovers the count and LBA fields after a control command. Either operation can run in 28-bit or 48-bit addressing.

Each access uses a request/acknowledge handshake on a small host-register port that carries address, direction and data. The sequencer raises `busy` while it works and pulses `done` when it finishes. `fail` then shows whether the BUSY wait timed out. A timed-out load never writes the command register. The timeout length is the parameter `TMO_CYCLES`.

Top module: `ata_tf_seq`

## Requirements
- R1: After reset `busy`, `done`, `fail` and `bus_req` are low, and `rb_count` and `rb_lba` are zero.
- R2: The port addresses are: 1 feature, 2 count, 3 sector, 4 cylinder-low, 5 cylinder-high, 6 drive, 7 command, and 14 device control (on a write) or alternate status (on a read). A load first writes drive = 0xE0 | unit<<4. It then reads alternate status until bit 7 (BUSY) is clear, and it writes no other register before that.
- R3: A status read that shows BUSY after at least `TMO_CYCLES` cycles of polling ends the load. `done` pulses, `fail` is set, and no further register is written, so the command register is never written.
- R4: Once BUSY is clear, a load writes device control = 0x08. The interrupt-disable bit (bit 1) is clear and HOB (bit 7) is clear.
- R5: A 28-bit load then writes feature[7:0], count[7:0], sector = LBA[7:0], cylinder-low = LBA[15:8] and cylinder-high = LBA[23:16]. It then writes drive = 0xE0 | unit<<4 | LBA[27:24].
- R6: A 48-bit load writes each shared register twice, high byte first: feature [15:8] then [7:0], count [15:8] then [7:0], sector LBA[31:24] then [7:0], cylinder-low LBA[39:32] then [15:8], cylinder-high LBA[47:40] then [23:16]. It then writes drive = 0x40 | unit<<4, with no address bits.
- R7: The command register is written last. `done` pulses with `fail` low in the cycle after that write is acknowledged.
- R8: A 48-bit readback writes device control = 0x88 (HOB set) and reads count, sector, cylinder-low and cylinder-high into count[15:8] and LBA[31:24], [39:32], [47:40]. It then writes 0x08 and reads the same four registers into count[7:0] and LBA[7:0], [15:8], [23:16].
- R9: A 28-bit readback reads count, sector, cylinder-low, cylinder-high and drive. It places the low nibble of the drive register in LBA[27:24] and clears count[15:8] and LBA[47:28].
- R10: `bus_req` makes one access per handshake. While it waits for `bus_ack`, `bus_addr`, `bus_wr` and `bus_wdata` stay stable, and `bus_req` drops in the cycle after an acknowledge.
- R11: A `start` pulse while `busy` is high is ignored. The running sequence keeps its latched request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| rb_mode | input | 1 | 0 = load, 1 = readback |
| wide | input | 1 | 1 = 48-bit addressing |
| cmd | input | 8 | Command opcode |
| feat | input | 16 | Feature value |
| count | input | 16 | Sector count |
| lba | input | 48 | Logical block address |
| unit | input | 1 | Device unit select |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Last sequence ended on BUSY timeout |
| bus_req | output | 1 | Register access request |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 4 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with acknowledge |
| bus_ack | input | 1 | Access acknowledge |
| rb_count | output | 16 | Count recovered by readback |
| rb_lba | output | 48 | LBA recovered by readback |

## Verification
The assertions assume that `bus_ack` arrives only while `bus_req` is high, and that `bus_rdata` is valid in the acknowledged cycle. The bench's device model raises acknowledge only against a pending request and never in two cycles in a row. It inserts random stall cycles and answers from its own register copies, which hold a previous and a current byte and are selected by HOB. As a result, a load followed by a readback checks the byte order end to end. Random requests, random busy lengths and random unit choices stay within this protocol. Directed cases cover the timeout, and a `start` pulse given mid-sequence.

// File: rtl/ata_tf_seq.sv
module ata_tf_seq #(
  parameter int TMO_CYCLES = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rb_mode,
  input  logic        wide,
  input  logic [7:0]  cmd,
  input  logic [15:0] feat,
  input  logic [15:0] count,
  input  logic [47:0] lba,
  input  logic        unit,
  output logic        busy,
  output logic        done,
  output logic        fail,
  output logic        bus_req,
  output logic        bus_wr,
  output logic [3:0]  bus_addr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  input  logic        bus_ack,
  output logic [15:0] rb_count,
  output logic [47:0] rb_lba
);
  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam logic [TW-1:0] TMO_L = TW'(TMO_CYCLES);
  localparam logic [3:0] A_FEAT = 4'd1, A_CNT = 4'd2, A_SEC = 4'd3, A_CLO = 4'd4,
                         A_CHI = 4'd5, A_DRV = 4'd6, A_CMD = 4'd7, A_CTL = 4'd14;
  localparam logic [7:0] CTL_ON = 8'h08, CTL_HOB = 8'h88;

  typedef enum logic [1:0] {K_WR, K_RD, K_POLL} kind_t;

  logic        busy_q, req_q, done_q, fail_q, op_q, ext_q, unit_q;
  logic [7:0]  cmd_q;
  logic [15:0] feat_q, cnt_q;
  logic [47:0] lba_q;
  logic [63:0] rb_q;
  logic [3:0]  step_q, last_step, slot;
  logic [TW-1:0] tcnt;
  kind_t       kind;
  logic [3:0]  a;
  logic [7:0]  wd, sel_drv;

  assign sel_drv = {3'b111, unit_q, 4'h0};

  always_comb begin
    kind = K_WR; a = A_CMD; wd = 8'h00; slot = 4'hF;
    case ({op_q, ext_q})
      2'b00, 2'b01: begin
        if (step_q == 4'd0) begin a = A_DRV; wd = sel_drv; end
        else if (step_q == 4'd1) begin kind = K_POLL; a = A_CTL; end
        else if (step_q == 4'd2) begin a = A_CTL; wd = CTL_ON; end
        else if (ext_q) begin
          case (step_q)
            4'd3:  begin a = A_FEAT; wd = feat_q[15:8];  end
            4'd4:  begin a = A_FEAT; wd = feat_q[7:0];   end
            4'd5:  begin a = A_CNT;  wd = cnt_q[15:8];   end
            4'd6:  begin a = A_CNT;  wd = cnt_q[7:0];    end
            4'd7:  begin a = A_SEC;  wd = lba_q[31:24];  end
            4'd8:  begin a = A_SEC;  wd = lba_q[7:0];    end
            4'd9:  begin a = A_CLO;  wd = lba_q[39:32];  end
            4'd10: begin a = A_CLO;  wd = lba_q[15:8];   end
            4'd11: begin a = A_CHI;  wd = lba_q[47:40];  end
            4'd12: begin a = A_CHI;  wd = lba_q[23:16];  end
            4'd13: begin a = A_DRV;  wd = {3'b010, unit_q, 4'h0}; end
            default: begin a = A_CMD; wd = cmd_q; end
          endcase
        end else begin
          case (step_q)
            4'd3: begin a = A_FEAT; wd = feat_q[7:0]; end
            4'd4: begin a = A_CNT;  wd = cnt_q[7:0];  end
            4'd5: begin a = A_SEC;  wd = lba_q[7:0];  end
            4'd6: begin a = A_CLO;  wd = lba_q[15:8]; end
            4'd7: begin a = A_CHI;  wd = lba_q[23:16]; end
            4'd8: begin a = A_DRV;  wd = sel_drv | {4'h0, lba_q[27:24]}; end
            default: begin a = A_CMD; wd = cmd_q; end
          endcase
        end
      end
      2'b10: begin
        kind = K_RD;
        case (step_q)
          4'd0: begin a = A_CNT; slot = 4'd6; end
          4'd1: begin a = A_SEC; slot = 4'd0; end
          4'd2: begin a = A_CLO; slot = 4'd1; end
          4'd3: begin a = A_CHI; slot = 4'd2; end
          default: begin a = A_DRV; slot = 4'd8; end
        endcase
      end
      default: begin
        kind = K_RD;
        case (step_q)
          4'd0: begin kind = K_WR; a = A_CTL; wd = CTL_HOB; end
          4'd1: begin a = A_CNT; slot = 4'd7; end
          4'd2: begin a = A_SEC; slot = 4'd3; end
          4'd3: begin a = A_CLO; slot = 4'd4; end
          4'd4: begin a = A_CHI; slot = 4'd5; end
          4'd5: begin kind = K_WR; a = A_CTL; wd = CTL_ON; end
          4'd6: begin a = A_CNT; slot = 4'd6; end
          4'd7: begin a = A_SEC; slot = 4'd0; end
          4'd8: begin a = A_CLO; slot = 4'd1; end
          default: begin a = A_CHI; slot = 4'd2; end
        endcase
      end
    endcase
  end

  always_comb begin
    case ({op_q, ext_q})
      2'b00:   last_step = 4'd9;
      2'b01:   last_step = 4'd14;
      2'b10:   last_step = 4'd4;
      default: last_step = 4'd9;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; req_q <= 1'b0; done_q <= 1'b0; fail_q <= 1'b0;
      op_q <= 1'b0; ext_q <= 1'b0; unit_q <= 1'b0; cmd_q <= '0;
      feat_q <= '0; cnt_q <= '0; lba_q <= '0; rb_q <= '0; step_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1; step_q <= '0; fail_q <= 1'b0;
          op_q <= rb_mode; ext_q <= wide; unit_q <= unit; cmd_q <= cmd;
          feat_q <= feat; cnt_q <= count; lba_q <= lba;
          if (rb_mode) rb_q <= '0;
        end
      end else if (!req_q) begin
        req_q <= 1'b1;
      end else if (bus_ack) begin
        req_q <= 1'b0;
        if (kind == K_POLL && bus_rdata[7]) begin
          if (tcnt >= TMO_L) begin
            busy_q <= 1'b0; done_q <= 1'b1; fail_q <= 1'b1;
          end
        end else begin
          if (kind == K_RD) begin
            if (slot == 4'd8) rb_q[27:24] <= bus_rdata[3:0];
            else              rb_q[{slot[2:0], 3'b000} +: 8] <= bus_rdata;
          end
          if (step_q == last_step) begin
            busy_q <= 1'b0; done_q <= 1'b1;
          end else begin
            step_q <= step_q + 4'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !busy_q || kind != K_POLL) tcnt <= '0;
    else if (tcnt != TMO_L)                  tcnt <= tcnt + 1'b1;
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign fail      = fail_q;
  assign bus_req   = req_q;
  assign bus_wr    = (kind == K_WR);
  assign bus_addr  = a;
  assign bus_wdata = wd;
  assign rb_count  = rb_q[63:48];
  assign rb_lba    = rb_q[47:0];

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wr) && $stable(bus_wdata));
  assert_req_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req);
  assert_cmd_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack && bus_wr && bus_addr == A_CMD |=> done && !fail);
  assert_tmo_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack && kind == K_POLL && bus_rdata[7] && tcnt < TMO_L |=> busy && !done);
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(lba_q) && $stable(op_q) && $stable(cmd_q));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_ata_tf_seq.sv
module sim_ata_tf_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rb_mode = 1'b0, wide = 1'b0, unit = 1'b0;
  logic [7:0] cmd = '0;
  logic [15:0] feat = '0, count = '0;
  logic [47:0] lba = '0;
  logic busy, done, fail, bus_req, bus_wr, bus_ack;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [15:0] rb_count;
  logic [47:0] rb_lba;

  int nchk = 0, nerr = 0, cyc = 0;
  int busy_init = 0;

  always #5 clk = ~clk;

  ata_tf_seq #(.TMO_CYCLES(40)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rb_mode(rb_mode), .wide(wide),
    .cmd(cmd), .feat(feat), .count(count), .lba(lba), .unit(unit),
    .busy(busy), .done(done), .fail(fail), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .rb_count(rb_count), .rb_lba(rb_lba));

  // device model: previous/current byte per shared register, HOB selects
  logic [7:0] cur [8];
  logic [7:0] prv [8];
  logic [7:0] drv = '0, ctl = '0;
  int busy_left = 0, nw = 0, early = 0;
  logic [11:0] wlog [32];
  logic m_ack = 1'b0;

  assign bus_ack = m_ack;

  always_comb begin
    case (bus_addr)
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5: bus_rdata = ctl[7] ? prv[bus_addr[2:0]] : cur[bus_addr[2:0]];
      4'd6:  bus_rdata = drv;
      4'd14: bus_rdata = (busy_left != 0) ? 8'h80 : 8'h50;
      default: bus_rdata = 8'h00;
    endcase
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    m_ack <= bus_req && !m_ack && ($urandom % 3 != 0);
    if (start && !busy) begin
      busy_left <= busy_init; nw <= 0; early <= 0;
    end else if (bus_req && m_ack) begin
      if (bus_wr) begin
        if (nw < 32) wlog[nw] <= {bus_addr, bus_wdata};
        nw <= nw + 1;
        if (busy_left != 0 && !(nw == 0 && bus_addr == 4'd6)) early <= early + 1;
        if (bus_addr >= 4'd1 && bus_addr <= 4'd5) begin
          prv[bus_addr[2:0]] <= cur[bus_addr[2:0]];
          cur[bus_addr[2:0]] <= bus_wdata;
        end
        if (bus_addr == 4'd6)  drv <= bus_wdata;
        if (bus_addr == 4'd14) ctl <= bus_wdata;
      end else if (bus_addr == 4'd14 && busy_left != 0) begin
        busy_left <= busy_left - 1;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      nerr = nerr + 1;
      $display("FAIL R0 watchdog expired: actual=%0d expected<=150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk + 1, nerr);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nerr = nerr + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [11:0] ex [32];
  int nex;

  task automatic build_load(input logic e, input logic [15:0] f, input logic [15:0] c,
                            input logic [47:0] l, input logic u, input logic [7:0] cm);
    nex = 0;
    ex[nex] = {4'd6, 8'hE0 | {3'b000, u, 4'h0}}; nex++;
    ex[nex] = {4'd14, 8'h08}; nex++;
    if (e) begin
      ex[nex] = {4'd1, f[15:8]};  nex++; ex[nex] = {4'd1, f[7:0]};   nex++;
      ex[nex] = {4'd2, c[15:8]};  nex++; ex[nex] = {4'd2, c[7:0]};   nex++;
      ex[nex] = {4'd3, l[31:24]}; nex++; ex[nex] = {4'd3, l[7:0]};   nex++;
      ex[nex] = {4'd4, l[39:32]}; nex++; ex[nex] = {4'd4, l[15:8]};  nex++;
      ex[nex] = {4'd5, l[47:40]}; nex++; ex[nex] = {4'd5, l[23:16]}; nex++;
      ex[nex] = {4'd6, 8'h40 | {3'b000, u, 4'h0}}; nex++;
    end else begin
      ex[nex] = {4'd1, f[7:0]};   nex++; ex[nex] = {4'd2, c[7:0]};   nex++;
      ex[nex] = {4'd3, l[7:0]};   nex++; ex[nex] = {4'd4, l[15:8]};  nex++;
      ex[nex] = {4'd5, l[23:16]}; nex++;
      ex[nex] = {4'd6, 8'hE0 | {3'b000, u, l[27:24]}}; nex++;
    end
    ex[nex] = {4'd7, cm}; nex++;
  endtask

  task automatic run_op(input logic op, input logic e, input logic [15:0] f, input logic [15:0] c,
                        input logic [47:0] l, input logic u, input logic [7:0] cm,
                        input int bz, input logic inject);
    @(negedge clk);
    rb_mode = op; wide = e; feat = f; count = c; lba = l; unit = u; cmd = cm;
    busy_init = bz; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (4) @(negedge clk);
      rb_mode = ~op; wide = ~e; lba = ~l; cmd = ~cm; feat = ~f; count = ~c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int n = 0; n < 5000 && !done; n++) @(negedge clk);
    chk("R7 done seen", {63'd0, done}, 64'd1);
  endtask

  task automatic cmp_log(input string tag);
    chk({tag, " write count"}, 64'(nw), 64'(nex));
    for (int i = 0; i < nex && i < 32; i++) chk(tag, {52'd0, wlog[i]}, {52'd0, ex[i]});
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin cur[i] = '0; prv[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 fail", {63'd0, fail}, 64'd0);
    chk("R1 req",  {63'd0, bus_req}, 64'd0);
    chk("R1 rb",   {rb_count, rb_lba}, 64'd0);
    rst_n = 1'b1;

    // 28-bit load then readback
    run_op(1'b0, 1'b0, 16'h12AB, 16'h0034, 48'h9876_5ABC_DEF1, 1'b1, 8'hC8, 3, 1'b0);
    chk("R7 fail after load", {63'd0, fail}, 64'd0);
    build_load(1'b0, 16'h12AB, 16'h0034, 48'h9876_5ABC_DEF1, 1'b1, 8'hC8);
    cmp_log("R5 28-bit order");
    chk("R2 nothing before BUSY clear", 64'(early), 64'd0);
    run_op(1'b1, 1'b0, 0, 0, 0, 1'b0, 0, 0, 1'b0);
    chk("R9 count", {48'd0, rb_count}, 64'h34);
    chk("R9 lba", {16'd0, rb_lba}, 64'h0000_0ABC_DEF1);

    // 48-bit load then readback
    run_op(1'b0, 1'b1, 16'hA55A, 16'hFEDC, 48'h1234_5678_9ABC, 1'b0, 8'h25, 5, 1'b0);
    build_load(1'b1, 16'hA55A, 16'hFEDC, 48'h1234_5678_9ABC, 1'b0, 8'h25);
    cmp_log("R6 48-bit order");
    chk("R4 ctl write", {52'd0, wlog[1]}, {52'd0, 4'd14, 8'h08});
    run_op(1'b1, 1'b1, 0, 0, 0, 1'b0, 0, 0, 1'b0);
    chk("R8 count", {48'd0, rb_count}, 64'hFEDC);
    chk("R8 lba", {16'd0, rb_lba}, 64'h1234_5678_9ABC);
    chk("R8 HOB left clear", {56'd0, ctl}, 64'h08);

    // start pulse while busy is ignored
    run_op(1'b0, 1'b1, 16'h0102, 16'h0304, 48'h0506_0708_090A, 1'b1, 8'h35, 2, 1'b1);
    build_load(1'b1, 16'h0102, 16'h0304, 48'h0506_0708_090A, 1'b1, 8'h35);
    cmp_log("R11 ignored start");
    @(negedge clk);
    chk("R11 idle after", {63'd0, busy}, 64'd0);

    // BUSY never clears: timeout
    run_op(1'b0, 1'b0, 16'h1111, 16'h2222, 48'h3333, 1'b0, 8'hEC, 100000, 1'b0);
    chk("R3 fail set", {63'd0, fail}, 64'd1);
    chk("R3 only select written", 64'(nw), 64'd1);
    chk("R3 select value", {52'd0, wlog[0]}, {52'd0, 4'd6, 8'hE0});

    // random round trips
    for (int k = 0; k < 24; k++) begin
      logic e, u;
      logic [15:0] f, c;
      logic [47:0] l;
      logic [7:0] cm;
      e = 1'($urandom % 2); u = 1'($urandom % 2);
      f = 16'($urandom); c = 16'($urandom); cm = 8'($urandom);
      l = {16'($urandom), 32'($urandom)};
      if (k == 0) l = 48'hFFFF_FFFF_FFFF;
      if (k == 1) l = 48'h0;
      run_op(1'b0, e, f, c, l, u, cm, int'($urandom % 4), 1'b0);
      build_load(e, f, c, l, u, cm);
      cmp_log(e ? "R6 random load" : "R5 random load");
      chk("R2 random early writes", 64'(early), 64'd0);
      run_op(1'b1, e, 0, 0, 0, 1'b0, 0, 0, 1'b0);
      if (e) begin
        chk("R8 random count", {48'd0, rb_count}, {48'd0, c});
        chk("R8 random lba", {16'd0, rb_lba}, {16'd0, l});
      end else begin
        chk("R9 random count", {48'd0, rb_count}, {56'd0, c[7:0]});
        chk("R9 random lba", {16'd0, rb_lba}, {36'd0, l[27:0]});
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule